// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a free-running watchdog counter clocked by the system clock. Software must restart it at regular intervals by writing its control register. If no restart arrives within the selected interval, a sticky warning flag is set and, when enabled, an interrupt is raised. A fixed lead time later (512 clocks by default), a system reset request is issued for a fixed number of clocks, provided that reset generation is enabled.

The interval is one of four powers of two: 2^12, 2^15, 2^18 or 2^21 clocks by default. Both the base exponent and the exponent step are parameters. A single 7-bit control register holds the following:
- the interval choice;
- the interrupt enable;
- the reset enable;
- a restart command;
- two write-one-to-clear status flags: the warning flag and the reset-occurred flag.

Software reads the register back on a separate read port. Clock generation and the distribution of the reset request are handled outside the block.

Top module: `wdog_early_warn`

## Requirements
- R1: After rst_n is released, rd_data reads 0, irq is 0 and rst_req is 0. The interval select is 0 and both enables are off.
- R2: The counter advances by one on every clock. The warning flag (rd_data bit 5) is set exactly 2^(BASE_LOG2+STEP_LOG2*sel) clocks after the last restart. irq equals the warning flag ANDed with the interrupt enable (register bit 2).
- R3: A register write with bit 4 set restarts the counter from zero. If restarts keep arriving within the interval, the warning flag never sets and rst_req never asserts. Bit 4 always reads back as 0.
- R4: The interval select occupies register bits [1:0]. A write that changes this field also restarts the counter.
- R5: When the reset enable (bit 3) is 1, rst_req rises exactly WARN_LEAD clocks after the warning flag sets. It then stays high for exactly PULSE_LEN clocks.
- R6: When the reset enable is 0, rst_req never asserts. Instead the counter wraps to zero at the point where the reset would have started, so the next warning comes one interval after that point.
- R7: The reset-occurred flag (bit 6) is set when rst_req rises. Writing 1 to bit 5 clears the warning flag, and writing 1 to bit 6 clears the reset-occurred flag; a flag being set in the same cycle wins over the clear. A restart clears neither flag.
- R8: When the interrupt enable is 0, irq stays low even though the warning flag is set.
- R9: The counter restarts from zero when rst_req rises, so the next warning comes one interval after the reset started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 7 | Control register write value |
| rd_data | output | 7 | Control register and status read value |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | System reset request pulse |

## Verification
The timeout path is exercised in several ways:
- Each of the four interval choices is measured from a restart to the warning. This separates correct exponent decoding from an off-by-one in the terminal count.
- A stream of restarts that always arrive in time tells a working restart apart from a counter that ignores it.
- A change of interval made mid-count shows whether a select change restarts the counter or leaves a stale count behind.
- With the reset enabled, the gap from warning to reset, the pulse width and the time to the next warning pin down the lead, the pulse length and the restart after a reset.
- With the reset disabled, the time to a second warning tells wrapping apart from saturating.

A behavioural reference model runs alongside and compares irq, rst_req and the read value on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int REG_W     = 7;
   localparam int SEL_W     = 2;
   localparam int N_SEL     = 1 << SEL_W;
   localparam int IE_BIT    = 2;
   localparam int RE_BIT    = 3;
   localparam int KICK_BIT  = 4;
   localparam int WARN_BIT  = 5;
   localparam int RFLAG_BIT = 6;

   typedef struct packed {
      logic             rst_en;
      logic             irq_en;
      logic [SEL_W-1:0] sel;
   } wdog_ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             warn_set,
   input  logic             fire,
   output wdog_ctl_t        ctl,
   output logic             restart,
   output logic             warn_flag,
   output logic             rst_flag
);
   logic sel_change;

   assign sel_change = wr_data[SEL_W-1:0] != ctl.sel;
   assign restart    = wr_en && (wr_data[KICK_BIT] || sel_change);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         warn_flag <= 1'b0;
         rst_flag  <= 1'b0;
      end else begin
         if (wr_en) begin
            ctl.sel    <= wr_data[SEL_W-1:0];
            ctl.irq_en <= wr_data[IE_BIT];
            ctl.rst_en <= wr_data[RE_BIT];
         end
         if (warn_set)
            warn_flag <= 1'b1;
         else if (wr_en && wr_data[WARN_BIT])
            warn_flag <= 1'b0;
         if (fire)
            rst_flag <= 1'b1;
         else if (wr_en && wr_data[RFLAG_BIT])
            rst_flag <= 1'b0;
      end
   end

   // R7: a write-one-to-clear without a concurrent set empties the flag
   a_r7_rflag_w1c : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[RFLAG_BIT] && !fire) |=> !rst_flag);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int BASE_LOG2 = 12,
   parameter int STEP_LOG2 = 3,
   parameter int WARN_LEAD = 512,
   parameter int CW        = BASE_LOG2 + STEP_LOG2*(N_SEL-1) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   input  logic             rst_en,
   output logic             warn_set,
   output logic             fire,
   output logic [CW-1:0]    cnt
);
   logic [CW-1:0] lim [N_SEL];
   logic [CW-1:0] term_val;
   logic          term;

   for (genvar g = 0; g < N_SEL; g++) begin : g_lim
      assign lim[g] = CW'(1) << (BASE_LOG2 + g*STEP_LOG2);
   end

   assign term_val = lim[sel] + CW'(WARN_LEAD - 1);
   assign term     = cnt == term_val;
   assign warn_set = !restart && (cnt == lim[sel] - CW'(1));
   assign fire     = !restart && term && rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || term)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

   // R3: a restart leaves the count at zero
   a_r3_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == '0);
   // R6: the count never passes the reset point of the current interval
   a_r6_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term_val);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_req
);
   localparam int PW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_req <= 1'b0;
         else        rst_req <= fire;
      end
   end else begin : g_multi
      logic [PW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            left <= '0;
         else if (fire)         left <= PW'(PULSE_LEN);
         else if (left != '0)   left <= left - PW'(1);
      end
      assign rst_req = left != '0;
   end

   logic [PW:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (rst_req) hi_len <= hi_len + (PW+1)'(1);
      else              hi_len <= '0;
   end

   // R5: every reset pulse lasts exactly PULSE_LEN clocks
   a_r5_pulse_len : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_req) |-> hi_len == (PW+1)'(PULSE_LEN));
endmodule

// File: rtl/wdog_early_warn.sv
module wdog_early_warn
   import wdog_pkg::*;
#(
   parameter int BASE_LOG2 = 12,
   parameter int STEP_LOG2 = 3,
   parameter int WARN_LEAD = 512,
   parameter int PULSE_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq,
   output logic             rst_req
);
   localparam int CW = BASE_LOG2 + STEP_LOG2*(N_SEL-1) + 1;

   if (BASE_LOG2 < 1 || STEP_LOG2 < 0) begin : g_bad_exp
      $error("wdog_early_warn: exponents out of range");
   end
   if (WARN_LEAD < 1 || WARN_LEAD >= (1 << BASE_LOG2)) begin : g_bad_lead
      $error("wdog_early_warn: WARN_LEAD must be below the shortest interval");
   end
   if (PULSE_LEN < 1 || PULSE_LEN >= (1 << BASE_LOG2)) begin : g_bad_pulse
      $error("wdog_early_warn: PULSE_LEN out of range");
   end

   wdog_ctl_t     ctl;
   logic          restart, warn_set, fire, warn_flag, rst_flag;
   logic [CW-1:0] cnt;

   wdog_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .warn_set(warn_set), .fire(fire), .ctl(ctl), .restart(restart),
      .warn_flag(warn_flag), .rst_flag(rst_flag)
   );

   wdog_counter #(
      .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2),
      .WARN_LEAD(WARN_LEAD), .CW(CW)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sel(ctl.sel),
      .rst_en(ctl.rst_en), .warn_set(warn_set), .fire(fire), .cnt(cnt)
   );

   wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .rst_req(rst_req)
   );

   assign irq     = warn_flag && ctl.irq_en;
   assign rd_data = {rst_flag, warn_flag, 1'b0, ctl.rst_en, ctl.irq_en, ctl.sel};

   // R7: the reset-occurred flag is up when the reset request rises
   a_r7_flag_on_reset : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> rst_flag);
   // R2: the warning appears with the count sitting on the selected interval
   a_r2_warn_at_limit : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_flag) |-> cnt == (CW'(1) << (BASE_LOG2 + STEP_LOG2*int'(ctl.sel))));
   // R9: the count starts over when a reset request begins
   a_r9_cnt_after_reset : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> cnt == '0);
endmodule

// File: tb/wdog_early_warn_test.sv
module wdog_early_warn_test;
   localparam int BASE = 6;
   localparam int STEP = 2;
   localparam int LEAD = 16;
   localparam int PUL  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [6:0] wr_data = '0;
   logic [6:0] rd_data;
   logic       irq, rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit seen_rst = 0;

   always #2.5 clk = ~clk;

   wdog_early_warn #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .WARN_LEAD(LEAD),
                     .PULSE_LEN(PUL)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
   );

   function automatic int tlen(int s);
      return 1 << (BASE + STEP*s);
   endfunction

   // behavioural reference model
   int m_cnt, m_sel, m_pulse;
   bit m_ie, m_re, m_warn, m_rflag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_sel = 0; m_pulse = 0;
         m_ie = 0; m_re = 0; m_warn = 0; m_rflag = 0;
      end else begin
         bit rs, term, fire, wset;
         rs   = wr_en && (wr_data[4] || int'(wr_data[1:0]) != m_sel);
         term = m_cnt == tlen(m_sel) + LEAD - 1;
         fire = term && !rs && m_re;
         wset = (m_cnt == tlen(m_sel) - 1) && !rs;
         m_cnt = (rs || term) ? 0 : m_cnt + 1;
         if (wset) m_warn = 1; else if (wr_en && wr_data[5]) m_warn = 0;
         if (fire) m_rflag = 1; else if (wr_en && wr_data[6]) m_rflag = 0;
         if (fire) m_pulse = PUL; else if (m_pulse > 0) m_pulse--;
         if (wr_en) begin
            m_sel = int'(wr_data[1:0]); m_ie = wr_data[2]; m_re = wr_data[3];
         end
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [6:0] exp_rd;
         exp_rd = {m_rflag, m_warn, 1'b0, m_re, m_ie, 2'(m_sel)};
         chk(irq == (m_warn && m_ie), "R2 irq vs model", irq, m_warn && m_ie);
         chk(rst_req == (m_pulse > 0), "R5 rst_req vs model", rst_req, m_pulse > 0);
         chk(rd_data == exp_rd, "R7 rd_data vs model", rd_data, exp_rd);
         if (rst_req) seen_rst = 1;
      end
   end

   task automatic wr(logic [6:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic until_warn(inout int n);
      while (!rd_data[5] && n < 20000) begin @(negedge clk); n++; end
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 0 && !irq && !rst_req, "R1 reset state", rd_data, 0);

      // R2: interval 0 with interrupt on
      wr(7'h14); n = 0; until_warn(n);
      chk(n == tlen(0), "R2 warn after interval 0", n, tlen(0));
      chk(irq == 1, "R2 irq raised", irq, 1);

      // R8: interrupt masked, flag still sets
      wr(7'h30); n = 0; until_warn(n);
      chk(n == tlen(0), "R8 warn timing masked", n, tlen(0));
      chk(irq == 0, "R8 irq masked", irq, 0);

      // R3: timely restarts prevent any warning or reset
      wr(7'h38);
      chk(rd_data[4] == 0, "R3 restart bit reads zero", rd_data[4], 0);
      seen_rst = 0;
      for (int i = 0; i < 6; i++) begin
         repeat (40) @(negedge clk);
         wr(7'h18);
      end
      chk(rd_data[5] == 0, "R3 no warn with restarts", rd_data[5], 0);
      chk(seen_rst == 0, "R3 no reset with restarts", seen_rst, 0);

      // R4: select change mid-count restarts the counter
      repeat (30) @(negedge clk);
      wr(7'h0D); n = 0; until_warn(n);
      chk(n == tlen(1), "R4 interval 1 after select change", n, tlen(1));

      // R5: lead from warning to reset, and pulse width
      n = 0;
      while (!rst_req && n < 1000) begin @(negedge clk); n++; end
      chk(n == LEAD, "R5 warn-to-reset lead", n, LEAD);
      chk(rd_data[6] == 1, "R7 reset flag set", rd_data[6], 1);
      n = 0;
      while (rst_req && n < 100) begin @(negedge clk); n++; end
      chk(n == PUL, "R5 pulse width", n, PUL);

      // R9: next warning one interval after reset start
      wr(7'h2D); n = n + 2; until_warn(n);
      chk(n == tlen(1), "R9 warn after reset restart", n, tlen(1));

      // R7: restart keeps flags; write-one clears
      wr(7'h1D);
      chk(rd_data[6:5] == 2'b11, "R7 restart keeps flags", rd_data[6:5], 3);
      wr(7'h71);
      chk(rd_data[6:5] == 2'b00, "R7 flags cleared", rd_data[6:5], 0);

      // R6: reset disabled, counter wraps
      seen_rst = 0;
      n = 0; until_warn(n);
      chk(n == tlen(1), "R6 first warn", n, tlen(1));
      wr(7'h21); n = n + 2; until_warn(n);
      chk(n == 2*tlen(1) + LEAD, "R6 wrap then warn again", n, 2*tlen(1) + LEAD);
      chk(seen_rst == 0 && rd_data[6] == 0, "R6 no reset issued", seen_rst, 0);

      // R4: the remaining intervals
      wr(7'h33); n = 0; until_warn(n);
      chk(n == tlen(3), "R4 interval 3", n, tlen(3));
      wr(7'h22); n = 0; until_warn(n);
      chk(n == tlen(2), "R4 interval 2", n, tlen(2));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule